// File: doc/BRIEF.md
# MDIO Management Master

This block is a master for the two-wire PHY management interface. It runs clause-22 read and write cycles against registers inside external PHYs. Software controls it through two registers: a command register and a data register. A single write to the command register picks the target PHY and register. The same write also sets the direction and the MDC divide ratio, and it launches the frame. Software then polls the busy bit until the frame on the wire has ended.

The block generates MDC from the system clock using a ratio chosen per transaction. It shifts out a 64-bit frame and drives MDIO through an output enable. For reads it releases the line at the turnaround, then samples sixteen data bits on the MDC rising edges. The result reaches the data register in the same clock edge that clears busy.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command register reads back as PHY address in bits 15:11, register number in bits 10:6, divider select in bits 5:2, write flag in bit 1 and busy in bit 0. Bits 31:16 of both registers read as zero. Out of reset both registers read 0.
- R2: A command-register write with bit 0 set while idle sets busy. Busy is visible in the following cycle and clears by itself once the last MDC cycle of the frame has finished.
- R3: A command-register write with bit 0 clear updates the stored fields but starts nothing. Busy stays 0, MDC stays low and the MDIO enable stays low. Whenever the block is idle, MDC is low and MDIO is not driven.
- R4: Divider select codes 0, 1, 2, 3, 4 and 5 give an MDC period of 42, 62, 16, 26, 102 and 124 system clocks. Every other code gives 124.
- R5: A frame is 64 MDC cycles, sent most significant bit first: 32 ones, then 01, then an opcode (10 = read, 01 = write), then the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround and 16 data bits.
- R6: In a write frame the master drives all 64 bits. The turnaround is 10 and the data field is the data-register value held when the frame started. The data register is left unchanged.
- R7: In a read frame the MDIO enable is low from bit 46 (the first turnaround bit) to the end of the frame. The 16 bits sampled on the MDC rising edges of bits 48 to 63, first one as MSB, appear in data-register bits 15:0 when busy reads 0.
- R8: While busy is set, writes to either register are ignored. Both read-back values stay constant and no second frame follows.
- R9: MDIO changes exactly one system clock after an MDC falling edge and is stable at the MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Write target: 0 = command register, 1 = data register |
| reg_wdata | input | 16 | Write data |
| addr_rdata | output | 32 | Command register read-back |
| data_rdata | output | 32 | Data register read-back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest case to reach from the ports is a register write that lands inside a running frame. It must change nothing: not the bits on the wire, not the read-back, and not the frame that follows. The bench issues such writes several hundred clocks into a frame, including a command write with bit 0 set. It then checks the captured frame, both read-backs and a quiet line after busy clears. A bench-side PHY model feeds read data on MDC falling edges, so the sampling point is exercised under every divider code.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants, command type and divider table for the MDIO master.
// Assumes clause-22 framing with a full 32-bit preamble.
package mdio_mgmt_pkg;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int SEL_W      = 4;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int CNT_W      = 8;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
    localparam int DATA_POS   = FRAME_BITS - DATA_W;

    // Map a divider select code to the MDC period in system clocks.
    function automatic logic [CNT_W-1:0] ratio_for(input logic [SEL_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            4'd0:    r = 8'd42;
            4'd1:    r = 8'd62;
            4'd2:    r = 8'd16;
            4'd3:    r = 8'd26;
            4'd4:    r = 8'd102;
            4'd5:    r = 8'd124;
            default: r = 8'd124;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/mdio_csr.sv
// Command and data registers of the MDIO master.
// Decodes a start request, holds the fields for read-back and captures read data.
// Assumes reg_we is a single-cycle strobe; writes are dropped while busy.
module mdio_csr
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [15:0]       reg_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              wr_active,
    input  logic [DATA_W-1:0] rd_value,
    output logic              start,
    output logic [PHY_W-1:0]  start_phy,
    output logic [REG_W-1:0]  start_reg,
    output logic [SEL_W-1:0]  start_sel,
    output logic              start_wr,
    output logic [DATA_W-1:0] tx_data,
    output logic [31:0]       addr_rdata,
    output logic [31:0]       data_rdata
);
    localparam int WR_BIT  = 1;
    localparam int SEL_LSB = 2;
    localparam int REG_LSB = SEL_LSB + SEL_W;
    localparam int PHY_LSB = REG_LSB + REG_W;

    logic [PHY_W-1:0]  phy_q;
    logic [REG_W-1:0]  reg_q;
    logic [SEL_W-1:0]  sel_q;
    logic              wr_q;
    logic [DATA_W-1:0] data_q;
    logic              cmd_wr, dat_wr;

    // Field decode of the incoming command word.
    assign start_phy = reg_wdata[PHY_LSB +: PHY_W];
    assign start_reg = reg_wdata[REG_LSB +: REG_W];
    assign start_sel = reg_wdata[SEL_LSB +: SEL_W];
    assign start_wr  = reg_wdata[WR_BIT];

    assign cmd_wr  = reg_we && !reg_sel && !busy;
    assign dat_wr  = reg_we &&  reg_sel && !busy;
    assign start   = cmd_wr && reg_wdata[0];
    assign tx_data = data_q;

    // Hold command fields written while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
            reg_q <= '0;
            sel_q <= '0;
            wr_q  <= 1'b0;
        end else if (cmd_wr) begin
            phy_q <= start_phy;
            reg_q <= start_reg;
            sel_q <= start_sel;
            wr_q  <= start_wr;
        end
    end

    // Data register: software write when idle, read result at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (dat_wr) begin
            data_q <= reg_wdata[DATA_W-1:0];
        end else if (done && !wr_active) begin
            data_q <= rd_value;
        end
    end

    assign addr_rdata = {16'h0000, phy_q, reg_q, sel_q, wr_q, busy};
    assign data_rdata = {{(32-DATA_W){1'b0}}, data_q};
endmodule

// File: rtl/mdio_mdc_gen.sv
// MDC generator: divides the system clock by a ratio latched at frame start.
// MDC is low for the first half of each bit period and high for the rest.
// Provides strobes for the rising edge and for the last clock of a bit.
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] start_sel,
    input  logic             active,
    output logic             mdc,
    output logic             rise,
    output logic             bit_end
);
    logic [CNT_W-1:0] ratio_q, half_q, cnt_q, next_ratio;

    assign next_ratio = ratio_for(start_sel);

    // Divider counter and per-frame ratio latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= ratio_for('0);
            half_q  <= ratio_for('0) >> 1;
            cnt_q   <= '0;
        end else if (start) begin
            ratio_q <= next_ratio;
            half_q  <= next_ratio >> 1;
            cnt_q   <= '0;
        end else if (active) begin
            cnt_q   <= bit_end ? '0 : cnt_q + 1'b1;
        end
    end

    assign bit_end = active && (cnt_q == ratio_q - 1'b1);
    assign rise    = active && (cnt_q == half_q);
    assign mdc     = active && (cnt_q >= half_q);
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: builds the 64-bit management frame at start, walks through it
// one bit per MDC period, drives MDIO one clock after each bit boundary and
// shifts in read data on MDC rising edges during the data phase.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PHY_W-1:0]  start_phy,
    input  logic [REG_W-1:0]  start_reg,
    input  logic              start_wr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rise,
    input  logic              bit_end,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              wr_active,
    output logic [DATA_W-1:0] rd_value,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic [FRAME_BITS-1:0] frame_q, frame_d;
    logic [IDX_W-1:0]      idx_q;
    logic                  busy_q, wr_q, last, drive_en, cur_bit;
    logic [DATA_W-1:0]     sh_q;
    logic                  mdio_o_q, oe_q;

    // Assemble the frame from the start fields.
    always_comb begin
        frame_d = {{PRE_BITS{1'b1}}, 2'b01,
                   (start_wr ? 2'b01 : 2'b10),
                   start_phy, start_reg,
                   (start_wr ? 2'b10 : 2'b00),
                   (start_wr ? start_data : {DATA_W{1'b0}})};
    end

    assign last     = (idx_q == IDX_W'(FRAME_BITS - 1));
    assign done     = bit_end && last;
    assign drive_en = wr_q || (idx_q < IDX_W'(TA_POS));
    assign cur_bit  = frame_q[IDX_W'(FRAME_BITS - 1) - idx_q];

    // Frame sequencing: busy flag, bit index and frame latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            wr_q    <= start_wr;
            idx_q   <= '0;
            frame_q <= frame_d;
        end else if (bit_end) begin
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q + 1'b1;
        end
    end

    // Read data capture on MDC rising edges in the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            sh_q <= '0;
        end else if (rise && (idx_q >= IDX_W'(DATA_POS))) begin
            sh_q <= {sh_q[DATA_W-2:0], mdio_i};
        end
    end

    // Pad drive, registered one clock behind the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdio_o_q <= 1'b1;
            oe_q     <= 1'b0;
        end else if (busy_q && !done) begin
            mdio_o_q <= cur_bit;
            oe_q     <= drive_en;
        end else begin
            mdio_o_q <= 1'b1;
            oe_q     <= 1'b0;
        end
    end

    assign busy      = busy_q;
    assign wr_active = wr_q;
    assign rd_value  = sh_q;
    assign mdio_o    = mdio_o_q;
    assign mdio_oe   = oe_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
// Top of the MDIO management master: register block, MDC generator and
// frame engine. One command write selects the target and starts the frame.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [31:0] addr_rdata,
    output logic [31:0] data_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start, start_wr, busy, done, wr_active, rise, bit_end;
    logic [PHY_W-1:0]  start_phy;
    logic [REG_W-1:0]  start_reg;
    logic [SEL_W-1:0]  start_sel;
    logic [DATA_W-1:0] tx_data, rd_value;

    mdio_csr u_csr (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .done(done),
        .wr_active(wr_active), .rd_value(rd_value), .start(start),
        .start_phy(start_phy), .start_reg(start_reg), .start_sel(start_sel),
        .start_wr(start_wr), .tx_data(tx_data),
        .addr_rdata(addr_rdata), .data_rdata(data_rdata)
    );

    mdio_mdc_gen u_mdc (
        .clk(clk), .rst_n(rst_n), .start(start), .start_sel(start_sel),
        .active(busy), .mdc(mdc), .rise(rise), .bit_end(bit_end)
    );

    mdio_frame_engine u_frame (
        .clk(clk), .rst_n(rst_n), .start(start), .start_phy(start_phy),
        .start_reg(start_reg), .start_wr(start_wr), .start_data(tx_data),
        .rise(rise), .bit_end(bit_end), .mdio_i(mdio_i), .busy(busy),
        .done(done), .wr_active(wr_active), .rd_value(rd_value),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_master_sva.sv
// Port-level protocol checks for the MDIO master, bound to the top module.
module mdio_mgmt_master_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic        reg_sel,
    input logic [15:0] reg_wdata,
    input logic [31:0] addr_rdata,
    input logic [31:0] data_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R2: an idle start request raises busy in the next cycle.
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel && reg_wdata[0] && !addr_rdata[0]) |=> addr_rdata[0]);

    // R3: an idle block keeps MDC low and the line released.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_rdata[0] |-> (!mdc && !mdio_oe));

    // R8: the data register is frozen during a frame.
    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_rdata[0] && $past(addr_rdata[0])) |-> $stable(data_rdata));

    // R8: the command read-back is frozen during a frame.
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_rdata[0] && $past(addr_rdata[0])) |-> $stable(addr_rdata));

    // R9: MDIO moves only one clock after an MDC falling edge.
    a_r9_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_rdata[0] && (mdio_o != $past(mdio_o))) |-> (!$past(mdc) && $past(mdc, 2)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_sva u_sva (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .addr_rdata(addr_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] addr_rdata, data_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    int   rise_total = 0;
    int   base = 0;
    logic [63:0] cap_o = '0, cap_oe = '0;
    time  t0 = 0, t1 = 0;
    logic [15:0] phy_val = '0;
    int unsigned seed_init;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_rdata(addr_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    // PHY model: capture the line at each MDC rise.
    always @(posedge mdc) begin
        int k;
        k = rise_total - base;
        if (k >= 0 && k < 64) begin
            cap_o[63-k]  = mdio_o;
            cap_oe[63-k] = mdio_oe;
            if (k == 0) t0 = $time;
            if (k == 1) t1 = $time;
        end
        rise_total++;
    end

    // PHY model: present read data after each MDC fall.
    always @(negedge mdc) begin
        int k;
        k = rise_total - base;
        if (k >= 48 && k <= 63) mdio_i = phy_val[63-k];
    end

    function automatic int exp_ratio(input logic [3:0] s);
        case (s)
            4'd0: return 42;
            4'd1: return 62;
            4'd2: return 16;
            4'd3: return 26;
            4'd4: return 102;
            4'd5: return 124;
            default: return 124;
        endcase
    endfunction

    function automatic logic [63:0] exp_frame(input logic [4:0] p, input logic [4:0] r,
                                              input logic w, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
                (w ? 2'b10 : 2'b00), (w ? d : 16'h0000)};
    endfunction

    function automatic logic [63:0] exp_oe(input logic w);
        return w ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run_txn(input logic [4:0] p, input logic [4:0] r, input logic [3:0] s,
                           input logic w, input logic [15:0] d, input bit disturb);
        logic [15:0] cmd, pre;
        logic [63:0] m;
        pre = data_rdata[15:0];
        if (w) wr_reg(1'b1, d);
        phy_val = w ? 16'($urandom) : d;
        cmd = {p, r, s, w, 1'b1};
        base = rise_total;
        wr_reg(1'b0, cmd);
        chk(addr_rdata[0] == 1'b1, "R2 busy after start", 64'(addr_rdata[0]), 64'd1);
        if (disturb) begin
            repeat (300) @(negedge clk);
            wr_reg(1'b1, ~d);
            wr_reg(1'b0, 16'($urandom) | 16'h1);
            @(negedge clk);
            chk(data_rdata[15:0] == (w ? d : pre), "R8 data write ignored",
                64'(data_rdata), 64'(w ? d : pre));
            chk(addr_rdata[15:1] == cmd[15:1], "R8 command write ignored",
                64'(addr_rdata), 64'(cmd));
        end
        while (addr_rdata[0]) @(negedge clk);
        m = exp_oe(w);
        chk(rise_total - base == 64, "R5 MDC cycles per frame",
            64'(rise_total - base), 64'd64);
        chk((cap_o & m) == (exp_frame(p, r, w, d) & m), w ? "R6 write frame bits" : "R5 read frame bits",
            cap_o & m, exp_frame(p, r, w, d) & m);
        chk(cap_oe == m, w ? "R6 enable during write" : "R7 release at turnaround", cap_oe, m);
        chk((t1 - t0) == time'(exp_ratio(s) * 20), "R4 MDC period",
            64'(t1 - t0), 64'(exp_ratio(s) * 20));
        chk(data_rdata == {16'h0, d}, w ? "R6 data register kept" : "R7 read data",
            64'(data_rdata), 64'(d));
        chk(addr_rdata == {16'h0, cmd[15:1], 1'b0}, "R1 command readback after frame",
            64'(addr_rdata), 64'({cmd[15:1], 1'b0}));
        repeat (3) @(negedge clk);
        chk(!mdc && !mdio_oe && !addr_rdata[0], "R3 quiet after frame",
            64'({mdc, mdio_oe, addr_rdata[0]}), 64'd0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R2 watchdog expired actual=busy expected=idle");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit q;
        seed_init = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_rdata == 32'h0 && data_rdata == 32'h0, "R1 reset values",
            64'({addr_rdata, data_rdata}), 64'd0);
        chk(!mdc && !mdio_oe, "R3 idle after reset", 64'({mdc, mdio_oe}), 64'd0);

        // R3: command write without start bit.
        wr_reg(1'b0, {5'd3, 5'd7, 4'd2, 1'b1, 1'b0});
        q = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mdc || mdio_oe || addr_rdata[0]) q = 1'b1;
        end
        chk(!q, "R3 no frame without start bit", 64'(q), 64'd0);
        chk(addr_rdata == 32'h0000_19CA, "R1 field placement", 64'(addr_rdata), 64'h19CA);

        // R4: every divider code, fallback code included.
        for (int c = 0; c < 6; c++)
            run_txn(5'(c + 1), 5'(c * 5), 4'(c), c[0], 16'($urandom), 1'b0);
        run_txn(5'd9, 5'd2, 4'd11, 1'b0, 16'hA5C3, 1'b0);

        // Corner cases: extreme fields, mid-frame disturbance.
        run_txn(5'd31, 5'd31, 4'd2, 1'b1, 16'hFFFF, 1'b0);
        run_txn(5'd0, 5'd0, 4'd2, 1'b0, 16'h0000, 1'b0);
        run_txn(5'd17, 5'd4, 4'd3, 1'b1, 16'h8001, 1'b1);
        run_txn(5'd6, 5'd22, 4'd3, 1'b0, 16'h7FFE, 1'b1);

        // Random traffic on the faster dividers.
        for (int n = 0; n < 20; n++)
            run_txn(5'($urandom), 5'($urandom), ($urandom % 2) ? 4'd2 : 4'd3,
                    1'($urandom), 16'($urandom), ($urandom % 4) == 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule